// File: doc/BRIEF.md
# Interval Timer with Time-of-Day Counter

This block is a memory-mapped timer peripheral on a plain 32-bit register bus. It does two jobs. First, it has a reloadable down-counter that raises an interrupt request once every programmed number of bus clock cycles. Second, it keeps a free-running wall clock held as a 64-bit seconds count and a nanoseconds count.

The control word programs three things: the enable, an 8-bit interrupt number and a 4-bit priority. The number and priority are presented next to the request so that an interrupt controller can route it. A build-time parameter selects a reduced mapping variant. In that variant only numbers 64 to 127 can be produced, and the priority is folded into the number.

The bus clock period in nanoseconds is fixed at build time and can be read back. Software uses it to turn cycle counts into time. To program a new interval, software writes the control word to zero, writes the reload value, and then writes the control word again with the enable bit set. Software reads the time as the nanoseconds word together with the seconds words.

Top module: `interval_tod_timer`

## Requirements
- R1: During and right after reset, every register reads zero except the bus-period word, and `irq_req` is low.
- R2: The register map is as follows:
  - 0x00: control word.
  - 0x10: reload value.
  - 0x14: live count (read-only).
  - 0x18: bus period in ns (read-only; returns `CLK_PERIOD_NS`).
  - 0x20 and 0x24: upper and lower seconds words.
  - 0x28: nanoseconds word.
  
  Writes to read-only offsets change nothing. Any other offset reads zero.
- R3: In the control word, bit 26 is enable, bits 23:20 are the priority and bits 19:12 are the interrupt number. All other bits are dropped. Reading the word back returns only these three fields, each at its own position.
- R4: A control write with bit 26 set loads the count with the reload value on that clock edge. Afterwards the count at 0x14 drops by one per cycle.
- R5: With reload value R ≥ 1, the first pulse on `irq_req` comes R cycles after the enabling write edge, and further pulses follow every R cycles. A reload value of 0 acts as 1, so the request pulses every cycle.
- R6: Each pulse is one cycle wide and is qualified by enable. After a control write that clears bit 26, no pulse appears from that edge onward, and the count holds its value.
- R7: A reload value written while the timer runs takes effect at the next reload. It does not disturb the countdown already in progress.
- R8: With the full mapping, `irq_num` and `irq_prio` equal the programmed number and priority.
- R9: With the reduced mapping, `irq_num` is built as follows:
  - bits 7:6 are 01;
  - bits 5:0 are the number's low six bits ORed with (priority << 2).
  
  `irq_prio` equals the programmed priority.
- R10: Every cycle the nanoseconds word grows by `CLK_PERIOD_NS`. When the sum reaches `SEC_NS`, `SEC_NS` is subtracted and the seconds count increases by one.
- R11: The seconds count is 64 bits wide. A carry out of the lower word at 0x24 increments the upper word at 0x20.
- R12: Software can write the seconds words and the nanoseconds word, and the written value appears at the next edge. A nanoseconds write of `SEC_NS` or more is dropped, and the counter keeps advancing normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | ADDR_W | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_req | output | 1 | One-cycle interrupt request pulse |
| irq_num | output | 8 | Effective interrupt number |
| irq_prio | output | 4 | Effective interrupt priority |

## Verification
The bench builds two copies of the block on the same bus, one with each mapping variant, so that every write to the control word checks both encodings at once. Both copies use a bus period of 7 ns and a one-second length of 100 ns instead of 10^9. With these values the nanoseconds word wraps about every fourteen cycles, and the remainder left after each wrap differs from one wrap to the next. This brings the wrap arithmetic and the carry into the seconds count within a few hundred cycles. The upper seconds word is reached by loading the lower word with all ones just before a wrap.

// File: rtl/itod_pkg.sv
// Shared constants and types for the interval timer with time-of-day counter.
// Assumes a 32-bit data bus with byte offsets; widths of sub-fields are fixed.
package itod_pkg;
    localparam int unsigned DATA_W   = 32;
    localparam int unsigned EN_BIT   = 26;
    localparam int unsigned PRIO_LSB = 20;
    localparam int unsigned PRIO_W   = 4;
    localparam int unsigned NUM_LSB  = 12;
    localparam int unsigned NUM_W    = 8;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_RELOAD = 8'h10;
    localparam logic [7:0] OFS_COUNT  = 8'h14;
    localparam logic [7:0] OFS_PERIOD = 8'h18;
    localparam logic [7:0] OFS_SEC_HI = 8'h20;
    localparam logic [7:0] OFS_SEC_LO = 8'h24;
    localparam logic [7:0] OFS_NSEC   = 8'h28;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] prio;
        logic [NUM_W-1:0]  num;
    } ctrl_t;
endpackage

// File: rtl/itod_regs.sv
// Control and reload registers plus the interrupt number/priority mapping.
// Assumes CNT_W <= 32. REDUCED_MAP selects the 64..127 number space in which
// the priority is folded into the number.
module itod_regs
    import itod_pkg::*;
#(
    parameter bit          REDUCED_MAP = 1'b0,
    parameter int unsigned CNT_W       = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_reload,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              start,
    output logic [NUM_W-1:0]  eff_num,
    output logic [PRIO_W-1:0] eff_prio
);
    localparam int unsigned LOW_W = NUM_W - 2;

    // Capture the three control fields; every other bit of the word is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.en   <= wdata[EN_BIT];
            ctrl.prio <= wdata[PRIO_LSB +: PRIO_W];
            ctrl.num  <= wdata[NUM_LSB +: NUM_W];
        end
    end

    // Hold the interval length in bus cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr_reload) begin
            reload <= wdata[CNT_W-1:0];
        end
    end

    // An enabling write restarts the countdown.
    always_comb start = wr_ctrl & wdata[EN_BIT];

    generate
        if (REDUCED_MAP) begin : g_reduced
            // Fold the priority into the low six bits and force the 64..127 window.
            always_comb begin
                eff_num  = {2'b01, ctrl.num[LOW_W-1:0] | LOW_W'({ctrl.prio, 2'b00})};
                eff_prio = ctrl.prio;
            end
        end else begin : g_full
            // Present the programmed fields unchanged.
            always_comb begin
                eff_num  = ctrl.num;
                eff_prio = ctrl.prio;
            end
        end
    endgenerate
endmodule

// File: rtl/itod_countdown.sv
// Reloadable down-counter. It shows values from R down to 1; in the cycle it
// would leave 1 it reloads and raises a registered one-cycle fire flag. A reload
// of 0 therefore fires every cycle. It holds its value while not running.
module itod_countdown #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             fire
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Load on start, otherwise count down and reload at the terminal value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (start) begin
                count <= reload;
            end else if (run) begin
                if (count <= ONE) begin
                    count <= reload;
                    fire  <= 1'b1;
                end else begin
                    count <= count - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/itod_tod.sv
// Time-of-day counter: nanoseconds advance by PERIOD_NS per cycle and wrap at
// SEC_NS into a 64-bit seconds count. Assumes 0 < PERIOD_NS < SEC_NS < 2^31.
// A valid nanoseconds write replaces the value and drops that cycle's carry.
module itod_tod
    import itod_pkg::*;
#(
    parameter int unsigned PERIOD_NS = 8,
    parameter int unsigned SEC_NS    = 1_000_000_000,
    parameter int unsigned NS_W      = $clog2(SEC_NS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sec_hi,
    input  logic              wr_sec_lo,
    input  logic              wr_nsec,
    input  logic [DATA_W-1:0] wdata,
    output logic [NS_W-1:0]   nsec,
    output logic [DATA_W-1:0] sec_hi,
    output logic [DATA_W-1:0] sec_lo
);
    localparam int unsigned       SUM_W = NS_W + 1;
    localparam logic [SUM_W-1:0]  STEP  = SUM_W'(PERIOD_NS);
    localparam logic [SUM_W-1:0]  LIMIT = SUM_W'(SEC_NS);

    logic [SUM_W-1:0]      sum;
    logic                  wrap;
    logic                  ns_load;
    logic [2*DATA_W-1:0]   sec_next;

    // Next-value arithmetic for the nanosecond and second counts.
    always_comb begin
        sum      = {1'b0, nsec} + STEP;
        ns_load  = wr_nsec && (wdata < DATA_W'(SEC_NS));
        wrap     = (sum >= LIMIT) && !ns_load;
        sec_next = {sec_hi, sec_lo} + (2*DATA_W)'(wrap);
    end

    // Nanoseconds register: a legal write wins, otherwise step and wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nsec <= '0;
        end else if (ns_load) begin
            nsec <= wdata[NS_W-1:0];
        end else if (sum >= LIMIT) begin
            nsec <= NS_W'(sum - LIMIT);
        end else begin
            nsec <= sum[NS_W-1:0];
        end
    end

    // Seconds words: a write to a word wins over the carry for that word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sec_hi <= '0;
            sec_lo <= '0;
        end else begin
            sec_hi <= wr_sec_hi ? wdata : sec_next[2*DATA_W-1:DATA_W];
            sec_lo <= wr_sec_lo ? wdata : sec_next[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/interval_tod_timer.sv
// Top of the interval timer with time-of-day counter: decodes the register
// bus, wires the control, countdown and time-of-day pieces together and
// gates the interrupt request with enable. Reads are combinational and have
// no side effects; a write takes one cycle with bus_wr high.
module interval_tod_timer
    import itod_pkg::*;
#(
    parameter int unsigned ADDR_W        = 8,
    parameter int unsigned CNT_W         = 32,
    parameter int unsigned CLK_PERIOD_NS = 8,
    parameter int unsigned SEC_NS        = 1_000_000_000,
    parameter bit          REDUCED_MAP   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_req,
    output logic [7:0]        irq_num,
    output logic [3:0]        irq_prio
);
    localparam int unsigned NS_W = $clog2(SEC_NS);

    ctrl_t              ctrl;
    logic               run;
    logic [CNT_W-1:0]   reload;
    logic [CNT_W-1:0]   count;
    logic               start;
    logic               fire;
    logic [NS_W-1:0]    nsec;
    logic [DATA_W-1:0]  sec_hi;
    logic [DATA_W-1:0]  sec_lo;
    logic [DATA_W-1:0]  ctrl_word;
    logic               wr_ctrl, wr_reload, wr_sec_hi, wr_sec_lo, wr_nsec;

    // Write strobes per writable register.
    always_comb begin
        wr_ctrl   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_reload = bus_wr && (bus_addr == ADDR_W'(OFS_RELOAD));
        wr_sec_hi = bus_wr && (bus_addr == ADDR_W'(OFS_SEC_HI));
        wr_sec_lo = bus_wr && (bus_addr == ADDR_W'(OFS_SEC_LO));
        wr_nsec   = bus_wr && (bus_addr == ADDR_W'(OFS_NSEC));
    end

    itod_regs #(
        .REDUCED_MAP (REDUCED_MAP),
        .CNT_W       (CNT_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wr_reload (wr_reload),
        .wdata     (bus_wdata),
        .ctrl      (ctrl),
        .reload    (reload),
        .start     (start),
        .eff_num   (irq_num),
        .eff_prio  (irq_prio)
    );

    always_comb run = ctrl.en;

    itod_countdown #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .run    (run),
        .reload (reload),
        .count  (count),
        .fire   (fire)
    );

    itod_tod #(
        .PERIOD_NS (CLK_PERIOD_NS),
        .SEC_NS    (SEC_NS),
        .NS_W      (NS_W)
    ) u_tod (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_sec_hi (wr_sec_hi),
        .wr_sec_lo (wr_sec_lo),
        .wr_nsec   (wr_nsec),
        .wdata     (bus_wdata),
        .nsec      (nsec),
        .sec_hi    (sec_hi),
        .sec_lo    (sec_lo)
    );

    // A fire that lands on the disabling edge is masked here.
    always_comb irq_req = fire & run;

    // Rebuild the control word with only its meaningful fields.
    always_comb begin
        ctrl_word                         = '0;
        ctrl_word[EN_BIT]                 = ctrl.en;
        ctrl_word[PRIO_LSB +: PRIO_W]     = ctrl.prio;
        ctrl_word[NUM_LSB +: NUM_W]       = ctrl.num;
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL):   bus_rdata = ctrl_word;
            ADDR_W'(OFS_RELOAD): bus_rdata = DATA_W'(reload);
            ADDR_W'(OFS_COUNT):  bus_rdata = DATA_W'(count);
            ADDR_W'(OFS_PERIOD): bus_rdata = DATA_W'(CLK_PERIOD_NS);
            ADDR_W'(OFS_SEC_HI): bus_rdata = sec_hi;
            ADDR_W'(OFS_SEC_LO): bus_rdata = sec_lo;
            ADDR_W'(OFS_NSEC):   bus_rdata = DATA_W'(nsec);
            default:             bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/itod_checker.sv
// Assertion checker for interval_tod_timer, attached by bind below.
// Assumes the same parameters as the instance it is bound to.
module itod_checker #(
    parameter int unsigned SEC_NS      = 1_000_000_000,
    parameter bit          REDUCED_MAP = 1'b0,
    parameter int unsigned CNT_W       = 32,
    parameter int unsigned NS_W        = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic             run,
    input logic             irq_req,
    input logic [7:0]       irq_num,
    input logic [3:0]       irq_prio,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload,
    input logic [NS_W-1:0]  nsec,
    input logic [31:0]      sec_hi,
    input logic [31:0]      sec_lo
);
    // R10: nanoseconds never reach one second.
    assert_ns_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        nsec < NS_W'(SEC_NS));

    // R11: a wrap of the nanoseconds bumps the 64-bit seconds by exactly one.
    assert_sec_carry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(nsec) > nsec) && !$past(bus_wr))
        |-> ({sec_hi, sec_lo} == $past({sec_hi, sec_lo}) + 64'd1));

    // R6: no request while disabled.
    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> run);

    // R6: a stopped counter keeps its value.
    assert_hold_when_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> $stable(count));

    // R5: every request coincides with a fresh reload.
    assert_reload_on_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !$past(bus_wr)) |-> (count == reload));

    generate
        if (REDUCED_MAP) begin : g_red
            // R9: the reduced number stays in 64..127 and carries the priority bits.
            assert_num_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (irq_num[7:6] == 2'b01) && ((irq_num[5:2] & irq_prio) == irq_prio));
        end else begin : g_full
            // R8: number and priority only move after a bus write.
            assert_map_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(bus_wr) |-> $stable({irq_num, irq_prio}));
        end
    endgenerate
endmodule

bind interval_tod_timer itod_checker #(
    .SEC_NS      (SEC_NS),
    .REDUCED_MAP (REDUCED_MAP),
    .CNT_W       (CNT_W),
    .NS_W        (NS_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .run      (run),
    .irq_req  (irq_req),
    .irq_num  (irq_num),
    .irq_prio (irq_prio),
    .count    (count),
    .reload   (reload),
    .nsec     (nsec),
    .sec_hi   (sec_hi),
    .sec_lo   (sec_lo)
);

// File: tb/sim_interval_tod_timer.sv
// Scoreboard bench: the driver pushes predicted pulse cycles into a queue, a
// monitor pops them as irq_req pulses appear. Register checks read the bus.
module sim_interval_tod_timer;
    localparam int unsigned P = 7;
    localparam int unsigned S = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] rdata0, rdata1;
    logic        irq0, irq1;
    logic [7:0]  num0, num1;
    logic [3:0]  prio0, prio1;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int exp_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    interval_tod_timer #(.CLK_PERIOD_NS(P), .SEC_NS(S), .REDUCED_MAP(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .irq_req(irq0),
        .irq_num(num0), .irq_prio(prio0));

    interval_tod_timer #(.CLK_PERIOD_NS(P), .SEC_NS(S), .REDUCED_MAP(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .irq_req(irq1),
        .irq_num(num1), .irq_prio(prio1));

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One write edge; returns the cycle index of that edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int wcyc);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        wcyc = cyc;
    endtask

    // Read in the current cycle without waiting for an edge.
    task automatic peek(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = rdata0;
    endtask

    // Read after the next falling edge.
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        peek(a, d);
    endtask

    // Monitor: every pulse of u0 must match the next predicted cycle.
    always @(negedge clk) begin
        if (rst_n && irq0) begin
            if (exp_q.size() == 0) check("R6 unexpected pulse", 64'(cyc), 64'hFFFF_FFFF);
            else check("R5 pulse cycle", 64'(cyc), 64'(exp_q.pop_front()));
        end
    end

    task automatic run_all();
        logic [31:0] d, d2, d3;
        int w, w2;
        logic [31:0] ens;
        logic [63:0] esec;

        repeat (3) @(negedge clk);
        // Reset state (R1)
        peek(8'h00, d); check("R1 ctrl", d, 0);
        peek(8'h28, d); check("R1 nsec", d, 0);
        peek(8'h24, d); check("R1 sec_lo", d, 0);
        rd(8'h14, d); check("R1 count", d, 0);
        peek(8'h10, d); check("R1 reload", d, 0);
        peek(8'h20, d); check("R1 sec_hi", d, 0);
        check("R1 irq", irq0, 0);
        rd(8'h18, d); check("R2 period in reset", d, P);
        rst_n = 1'b1;

        // Map, read-only and unmapped offsets (R2)
        rd(8'h18, d); check("R2 period", d, P);
        wr(8'h18, 32'd99, w);
        peek(8'h18, d); check("R2 period write ignored", d, P);
        peek(8'h04, d); check("R2 unmapped 04", d, 0);
        peek(8'h2C, d); check("R2 unmapped 2C", d, 0);
        wr(8'h14, 32'd1234, w);
        peek(8'h14, d); check("R2 count write ignored", d, 0);

        // Control fields and mappings (R3, R8, R9)
        wr(8'h00, 32'h80A9_C001, w);
        peek(8'h00, d); check("R3 ctrl readback", d, 32'h00A9_C000);
        check("R8 num full", num0, 8'h9C);
        check("R8 prio full", prio0, 4'hA);
        check("R9 num reduced", num1, 8'h7C);
        check("R9 prio reduced", prio1, 4'hA);
        wr(8'h00, 32'h000C_3000, w);
        check("R8 num full 2", num0, 8'hC3);
        check("R9 num reduced 2", num1, 8'h43);
        check("R9 prio reduced 2", prio1, 4'h0);

        // Periodic operation with reload 5 (R4, R5, R6)
        wr(8'h10, 32'd5, w);
        peek(8'h10, d); check("R4 reload readback", d, 5);
        wr(8'h00, 32'h0400_0000, w);
        exp_q.push_back(w + 5); exp_q.push_back(w + 10); exp_q.push_back(w + 15);
        peek(8'h14, d); check("R4 count loaded", d, 5);
        rd(8'h14, d); check("R4 count decrements", d, 4);
        while (cyc < w + 16) @(negedge clk);
        wr(8'h00, 32'h0, w2);
        rd(8'h14, d); repeat (3) @(negedge clk); peek(8'h14, d2);
        check("R6 count holds", d2, d);
        repeat (10) @(negedge clk);
        check("R6 no pending pulses", 64'(exp_q.size()), 0);

        // Reload change while running (R7)
        wr(8'h10, 32'd4, w);
        wr(8'h00, 32'h0400_0000, w);
        wr(8'h10, 32'd6, w2);
        exp_q.push_back(w + 4); exp_q.push_back(w + 10); exp_q.push_back(w + 16);
        while (cyc < w + 17) @(negedge clk);
        wr(8'h00, 32'h0, w2);
        repeat (10) @(negedge clk);
        check("R7 all pulses seen", 64'(exp_q.size()), 0);

        // Reload 0 fires every cycle (R5)
        wr(8'h10, 32'd0, w);
        wr(8'h00, 32'h0400_0000, w);
        exp_q.push_back(w + 1); exp_q.push_back(w + 2); exp_q.push_back(w + 3);
        while (cyc < w + 2) @(negedge clk);
        wr(8'h00, 32'h0, w2);
        repeat (5) @(negedge clk);
        check("R5 reload zero pulses", 64'(exp_q.size()), 0);

        // Time of day: wrap and 64-bit carry (R10, R11, R12)
        wr(8'h28, 32'd0, w);
        wr(8'h20, 32'd5, w);
        wr(8'h24, 32'hFFFF_FFFF, w);
        wr(8'h28, 32'd90, w);
        peek(8'h28, d); check("R12 nsec written", d, 90);
        peek(8'h24, d2); check("R12 sec_lo written", d2, 32'hFFFF_FFFF);
        peek(8'h20, d3); check("R12 sec_hi written", d3, 5);
        rd(8'h28, d); check("R10 nsec step", d, 97);
        rd(8'h28, d); check("R10 nsec wrap", d, 4);
        peek(8'h24, d2); check("R11 sec_lo wraps", d2, 0);
        peek(8'h20, d3); check("R11 sec_hi carry", d3, 6);
        ens = 4; esec = 64'h6_0000_0000;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            ens += P;
            if (ens >= S) begin ens -= S; esec++; end
            peek(8'h28, d); check("R10 nsec run", d, ens);
            peek(8'h24, d2); check("R10 sec run", d2, esec[31:0]);
        end
        wr(8'h28, 32'd150, w);
        for (int k = 0; k < 2; k++) begin
            ens += P;
            if (ens >= S) begin ens -= S; esec++; end
        end
        peek(8'h28, d); check("R12 illegal nsec ignored", d, ens);
        wr(8'h28, 32'd42, w);
        peek(8'h28, d); check("R12 nsec reload", d, 42);
        wr(8'h24, 32'h1234, w);
        peek(8'h24, d); check("R12 sec_lo reload", d, 32'h1234);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog (all requirements): actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule